// File: doc/BRIEF.md
# Debug Comparator Condition Qualifier

This block sits after a bank of hardware breakpoint or watchpoint address comparators. Each comparator reports an address hit. For every hit, the qualifier then checks the remaining conditions held in that comparator's control word. These are the security state it accepts, the privilege levels it accepts, and an optional link to a context-ID comparator. It then reports whether any comparator should raise a debug exception, which comparator has the lowest index among those that qualify, and the fault status code to record.

One input selects whether the bank is being evaluated as watchpoints or as breakpoints. In watchpoint mode, an access flagged as unprivileged is judged as if it came from level 0. Two global enables gate every result. The context ID and the link slot registers (control and value) are plain inputs. The result is registered, so it appears one cycle after the inputs.

Top module: `dbg_cond_match`

## Requirements
- R1: A comparator can only qualify when its hit flag is high and its control bit 0 (enable) is set.
- R2: Control bits [15:14] select the security filter: 0 accepts either state, 1 and 3 accept only the non-secure state (`secure_i`=0), and 2 accepts only the secure state.
- R3: The access level selects a privilege check. Level 2 or 3 requires control bit 13. Level 1 requires control bit 1. Level 0 requires control bit 2.
- R4: When `is_wp_i` is high and `unpriv_i` is high, the access level is taken as 0 regardless of `cur_lvl_i`. When `is_wp_i` is low, `unpriv_i` has no effect.
- R5: No match is reported unless both `mon_en_i` and `exc_en_i` are high.
- R6: When control bit 20 is set, the link number in control bits [19:16] must lie in the window BRP_LAST-CTX_CNT to BRP_LAST (inclusive), otherwise the comparator fails.
- R7: A link slot passes only if all of the following hold: its control bit 0 is set, its type field bits [23:20] equals 3, `cur_lvl_i` is at most 1, and its value equals `ctx_id_i`.
- R8: On a match, `fsr_o` is 10'h222 when `long_desc_i` is high and 10'h002 otherwise. With no match, it is 0.
- R9: `match_o` is the OR of all comparator results. `idx_o` is the lowest qualifying index, and 0 with no match.
- R10: Outputs are registered, reflecting inputs of the previous rising edge. While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_i | input | NUM_CMP | Per-comparator address hit |
| ctrl_i | input | NUM_CMP*32 | Per-comparator control words, comparator i at [32i+31:32i] |
| is_wp_i | input | 1 | Evaluate the bank as watchpoints |
| unpriv_i | input | 1 | Access flagged unprivileged |
| cur_lvl_i | input | 2 | Current privilege level 0..3 |
| secure_i | input | 1 | Current security state (1 = secure) |
| mon_en_i | input | 1 | Global monitor enable bit |
| exc_en_i | input | 1 | Debug exceptions currently permitted |
| long_desc_i | input | 1 | Long descriptor fault format active |
| ctx_id_i | input | CTX_W | Current context ID |
| link_ctrl_i | input | LINK_SLOTS*32 | Link slot control words |
| link_val_i | input | LINK_SLOTS*CTX_W | Link slot context values |
| match_o | output | 1 | Some comparator qualifies |
| idx_o | output | IDX_W | Lowest qualifying comparator index |
| fsr_o | output | 10 | Fault status code |

## Verification
A linked match is the hardest result to produce. It needs six things at once: an address hit, an enabled comparator with link enable, a link number inside the narrow window, a slot that is enabled and typed 3, a current level of at most 1, and a context ID equal to the slot value. The random stimulus is biased so that link numbers cluster around the window edges, half of the slots carry type 3, and half of the slot values are copied from the context ID. Directed vectors then move exactly one of these conditions at a time out of its passing state.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;
  localparam int CTRL_W   = 32;
  localparam int LBN_W    = 4;
  localparam int FSR_W    = 10;
  localparam int EN_B     = 0;
  localparam int PRIV_LO  = 1;
  localparam int HLE_B    = 13;
  localparam int SEC_LO   = 14;
  localparam int LBN_LO   = 16;
  localparam int LINKEN_B = 20;
  localparam int TYPE_LO  = 20;
  localparam logic [3:0]       LINK_TYPE_CTX = 4'd3;
  localparam logic [FSR_W-1:0] FSR_LONG      = 10'h222;
  localparam logic [FSR_W-1:0] FSR_SHORT     = 10'h002;

  function automatic logic sec_pass(input logic [1:0] fld, input logic secure);
    case (fld)
      2'd0:    return 1'b1;
      2'd2:    return secure;
      default: return !secure;
    endcase
  endfunction

  function automatic logic lvl_pass(input logic [1:0] lvl, input logic [1:0] priv,
                                    input logic hle);
    case (lvl)
      2'd0:    return priv[1];
      2'd1:    return priv[0];
      default: return hle;
    endcase
  endfunction
endpackage

// File: rtl/dbgm_link_eval.sv
module dbgm_link_eval
  import dbgm_pkg::*;
#(
  parameter int LINK_SLOTS = 16,
  parameter int CTX_W      = 32,
  parameter int BRP_LAST   = 5,
  parameter int CTX_CNT    = 1
) (
  input  logic [LBN_W-1:0]            lbn_i,
  input  logic [LINK_SLOTS*CTRL_W-1:0] link_ctrl_i,
  input  logic [LINK_SLOTS*CTX_W-1:0]  link_val_i,
  input  logic [1:0]                  cur_lvl_i,
  input  logic [CTX_W-1:0]            ctx_id_i,
  output logic                        link_ok_o
);
  localparam int WIN_LO = BRP_LAST - CTX_CNT;
  localparam int SEL_W  = (LINK_SLOTS > 1) ? $clog2(LINK_SLOTS) : 1;

  logic              in_win;
  logic [SEL_W-1:0]  sel;
  logic [CTRL_W-1:0] slot_ctrl;
  logic [CTX_W-1:0]  slot_val;

  always_comb begin
    in_win = (int'(lbn_i) <= BRP_LAST) && (int'(lbn_i) >= WIN_LO) &&
             (int'(lbn_i) < LINK_SLOTS);
    sel       = in_win ? SEL_W'(lbn_i) : '0;
    slot_ctrl = link_ctrl_i[sel*CTRL_W +: CTRL_W];
    slot_val  = link_val_i[sel*CTX_W +: CTX_W];
    // context comparison never fires above level 1
    link_ok_o = in_win && slot_ctrl[EN_B] &&
                (slot_ctrl[TYPE_LO +: 4] == LINK_TYPE_CTX) &&
                (cur_lvl_i <= 2'd1) && (slot_val == ctx_id_i);
  end
endmodule

// File: rtl/dbgm_cmp_qual.sv
module dbgm_cmp_qual
  import dbgm_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              hit_i,
  input  logic              is_wp_i,
  input  logic              unpriv_i,
  input  logic [1:0]        cur_lvl_i,
  input  logic              secure_i,
  input  logic              link_ok_i,
  output logic              ok_o
);
  logic [1:0] acc_lvl;
  logic       base_ok, link_pass;

  always_comb begin
    acc_lvl   = (is_wp_i && unpriv_i) ? 2'd0 : cur_lvl_i;
    base_ok   = hit_i && ctrl_i[EN_B] &&
                sec_pass(ctrl_i[SEC_LO +: 2], secure_i) &&
                lvl_pass(acc_lvl, ctrl_i[PRIV_LO +: 2], ctrl_i[HLE_B]);
    link_pass = !ctrl_i[LINKEN_B] || link_ok_i;
    ok_o      = base_ok && link_pass;
  end
endmodule

// File: rtl/dbgm_first.sv
module dbgm_first #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/dbg_cond_match.sv
module dbg_cond_match
  import dbgm_pkg::*;
#(
  parameter int NUM_CMP    = 4,
  parameter int LINK_SLOTS = 16,
  parameter int CTX_W      = 32,
  parameter int BRP_LAST   = 5,
  parameter int CTX_CNT    = 1,
  localparam int IDX_W     = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_CMP-1:0]           hit_i,
  input  logic [NUM_CMP*CTRL_W-1:0]    ctrl_i,
  input  logic                         is_wp_i,
  input  logic                         unpriv_i,
  input  logic [1:0]                   cur_lvl_i,
  input  logic                         secure_i,
  input  logic                         mon_en_i,
  input  logic                         exc_en_i,
  input  logic                         long_desc_i,
  input  logic [CTX_W-1:0]             ctx_id_i,
  input  logic [LINK_SLOTS*CTRL_W-1:0] link_ctrl_i,
  input  logic [LINK_SLOTS*CTX_W-1:0]  link_val_i,
  output logic                         match_o,
  output logic [IDX_W-1:0]             idx_o,
  output logic [FSR_W-1:0]             fsr_o
);
  logic [NUM_CMP-1:0] cmp_ok;
  logic               any_ok, gate, hit_now;
  logic [IDX_W-1:0]   first_idx;

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    logic [CTRL_W-1:0] c;
    logic              lk;
    assign c = ctrl_i[g*CTRL_W +: CTRL_W];

    dbgm_link_eval #(
      .LINK_SLOTS(LINK_SLOTS), .CTX_W(CTX_W),
      .BRP_LAST(BRP_LAST), .CTX_CNT(CTX_CNT)
    ) u_link (
      .lbn_i      (c[LBN_LO +: LBN_W]),
      .link_ctrl_i(link_ctrl_i),
      .link_val_i (link_val_i),
      .cur_lvl_i  (cur_lvl_i),
      .ctx_id_i   (ctx_id_i),
      .link_ok_o  (lk)
    );

    dbgm_cmp_qual u_qual (
      .ctrl_i   (c),
      .hit_i    (hit_i[g]),
      .is_wp_i  (is_wp_i),
      .unpriv_i (unpriv_i),
      .cur_lvl_i(cur_lvl_i),
      .secure_i (secure_i),
      .link_ok_i(lk),
      .ok_o     (cmp_ok[g])
    );
  end

  dbgm_first #(.N(NUM_CMP), .IDX_W(IDX_W)) u_first (
    .req_i(cmp_ok),
    .any_o(any_ok),
    .idx_o(first_idx)
  );

  assign gate    = mon_en_i && exc_en_i;
  assign hit_now = gate && any_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_o <= 1'b0;
      idx_o   <= '0;
      fsr_o   <= '0;
    end else begin
      match_o <= hit_now;
      idx_o   <= hit_now ? first_idx : '0;
      fsr_o   <= !hit_now ? '0 : (long_desc_i ? FSR_LONG : FSR_SHORT);
    end
  end
endmodule

// File: rtl/dbgm_sva.sv
module dbgm_sva
  import dbgm_pkg::*;
#(
  parameter int NUM_CMP = 4,
  parameter int IDX_W   = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_CMP-1:0] hit_i,
  input logic               mon_en_i,
  input logic               exc_en_i,
  input logic               long_desc_i,
  input logic               match_o,
  input logic [IDX_W-1:0]   idx_o,
  input logic [FSR_W-1:0]   fsr_o
);
  logic [NUM_CMP-1:0] hit_q;
  logic               gate_q, long_q, seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q  <= '0;
      gate_q <= 1'b0;
      long_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      hit_q  <= hit_i;
      gate_q <= mon_en_i && exc_en_i;
      long_q <= long_desc_i;
      seen_q <= 1'b1;
    end
  end

  AST_MATCH_HAS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && match_o) |-> hit_q[idx_o]);                               // R1
  AST_GATED_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !gate_q) |-> !match_o);                                   // R5
  AST_FSR_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && match_o) |-> (fsr_o == (long_q ? FSR_LONG : FSR_SHORT))); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_o |-> (idx_o == '0 && fsr_o == '0));                          // R9
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (int'(idx_o) < NUM_CMP));                                // R9
  AST_NO_HIT_NO_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && hit_q == '0) |-> !match_o);                               // R10
endmodule

bind dbg_cond_match dbgm_sva #(.NUM_CMP(NUM_CMP), .IDX_W(IDX_W)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit_i), .mon_en_i(mon_en_i),
  .exc_en_i(exc_en_i), .long_desc_i(long_desc_i), .match_o(match_o),
  .idx_o(idx_o), .fsr_o(fsr_o)
);

// File: tb/dbg_cond_match_test.sv
module dbg_cond_match_test;
  localparam int N   = 4;
  localparam int L   = 16;
  localparam int CW  = 32;
  localparam int BL  = 5;
  localparam int CC  = 1;
  localparam int IW  = 2;

  logic            clk = 1'b0, rst_ni = 1'b0;
  logic [N-1:0]    hit;
  logic [N*32-1:0] ctrl;
  logic            is_wp, unpriv, secure, mon_en, exc_en, long_d;
  logic [1:0]      cur;
  logic [CW-1:0]   ctx;
  logic [L*32-1:0] lctrl;
  logic [L*CW-1:0] lval;
  logic            match;
  logic [IW-1:0]   idx;
  logic [9:0]      fsr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dbg_cond_match #(.NUM_CMP(N), .LINK_SLOTS(L), .CTX_W(CW), .BRP_LAST(BL), .CTX_CNT(CC)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .hit_i(hit), .ctrl_i(ctrl), .is_wp_i(is_wp),
    .unpriv_i(unpriv), .cur_lvl_i(cur), .secure_i(secure), .mon_en_i(mon_en),
    .exc_en_i(exc_en), .long_desc_i(long_d), .ctx_id_i(ctx), .link_ctrl_i(lctrl),
    .link_val_i(lval), .match_o(match), .idx_o(idx), .fsr_o(fsr)
  );

  function automatic logic [31:0] mk(int en, int priv, int hle, int sec, int lbn, int lnk);
    return 32'(en & 1) | (32'(priv & 3) << 1) | (32'(hle & 1) << 13) |
           (32'(sec & 3) << 14) | (32'(lbn & 15) << 16) | (32'(lnk & 1) << 20);
  endfunction

  function automatic bit ref_cmp(int i);
    logic [31:0] c = ctrl[i*32 +: 32];
    int acc, s, lb;
    logic [31:0] lc;
    if (!hit[i] || !c[0]) return 0;
    acc = (is_wp && unpriv) ? 0 : int'(cur);
    s = int'(c[15:14]);
    if (s == 2 && !secure) return 0;
    if ((s == 1 || s == 3) && secure) return 0;
    if (acc >= 2 && !c[13]) return 0;
    if (acc == 1 && !c[1]) return 0;
    if (acc == 0 && !c[2]) return 0;
    if (c[20]) begin
      lb = int'(c[19:16]);
      if (lb > BL || lb < BL - CC) return 0;
      lc = lctrl[lb*32 +: 32];
      if (!lc[0] || lc[23:20] != 4'd3 || cur > 2'd1) return 0;
      if (lval[lb*CW +: CW] != ctx) return 0;
    end
    return 1;
  endfunction

  task automatic cmp(string tag);
    bit em = 0; int ei = 0; int ef = 0;
    if (mon_en && exc_en)
      for (int i = 0; i < N; i++) if (!em && ref_cmp(i)) begin em = 1; ei = i; end
    if (em) ef = long_d ? 'h222 : 'h002;
    checks++;
    if (match !== em || int'(idx) != ei || int'(fsr) != ef) begin
      fails++;
      $display("FAIL %s: got match=%0b idx=%0d fsr=%h expected match=%0b idx=%0d fsr=%h",
               tag, match, idx, fsr, em, ei, ef);
    end
  endtask

  task automatic apply(string tag);
    @(posedge clk); #2; cmp(tag); @(negedge clk);
  endtask

  task automatic base();
    hit = '0; is_wp = 0; unpriv = 0; secure = 0; mon_en = 1; exc_en = 1;
    long_d = 0; cur = 2'd1; ctx = 32'hCAFE_0001;
    for (int i = 0; i < N; i++) ctrl[i*32 +: 32] = mk(1, 3, 1, 0, 0, 0);
    for (int j = 0; j < L; j++) begin
      lctrl[j*32 +: 32] = 32'h1 | (32'd3 << 20);
      lval[j*CW +: CW] = ctx;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    base();
    hit = '1;
    repeat (3) @(negedge clk);
    checks++;
    if (match !== 1'b0 || idx !== '0 || fsr !== '0) begin
      fails++; $display("FAIL R10 reset: got %0b/%0d/%h expected 0/0/0", match, idx, fsr);
    end
    rst_ni = 1;
    hit = '0;
    apply("R10 after reset");
    // R10: output changes only at the next edge
    hit = 4'b0001; #1;
    checks++;
    if (match !== 1'b0) begin fails++; $display("FAIL R10 early: got %0b expected 0", match); end
    apply("R10 registered");
    // R1
    base(); apply("R1 no hit");
    hit = 4'b0100; ctrl[2*32] = 1'b0; apply("R1 disabled comparator");
    ctrl[2*32] = 1'b1; apply("R1 enabled comparator");
    // R2
    base(); hit = 4'b0001;
    ctrl[31:0] = mk(1, 3, 1, 2, 0, 0); apply("R2 sec2 nonsecure");
    secure = 1; apply("R2 sec2 secure");
    ctrl[31:0] = mk(1, 3, 1, 1, 0, 0); apply("R2 sec1 secure");
    ctrl[31:0] = mk(1, 3, 1, 3, 0, 0); secure = 0; apply("R2 sec3 nonsecure");
    // R3
    base(); hit = 4'b0001;
    ctrl[31:0] = mk(1, 2, 0, 0, 0, 0); apply("R3 level1 priv bit0 clear");
    cur = 2'd0; apply("R3 level0 priv bit1 set");
    cur = 2'd3; apply("R3 level3 no higher enable");
    ctrl[31:0] = mk(1, 0, 1, 0, 0, 0); apply("R3 level3 higher enable");
    // R4
    base(); hit = 4'b0001; ctrl[31:0] = mk(1, 2, 0, 0, 0, 0); cur = 2'd2;
    is_wp = 1; unpriv = 1; apply("R4 unpriv watch as level0");
    is_wp = 0; apply("R4 unpriv ignored for breakpoints");
    // R5
    base(); hit = 4'b0001;
    mon_en = 0; apply("R5 monitor disabled");
    mon_en = 1; exc_en = 0; apply("R5 exceptions disabled");
    // R6
    base(); hit = 4'b0001;
    ctrl[31:0] = mk(1, 3, 1, 0, 3, 1); apply("R6 link below window");
    ctrl[31:0] = mk(1, 3, 1, 0, 4, 1); apply("R6 link window low edge");
    ctrl[31:0] = mk(1, 3, 1, 0, 5, 1); apply("R6 link window high edge");
    ctrl[31:0] = mk(1, 3, 1, 0, 6, 1); apply("R6 link above window");
    // R7
    base(); hit = 4'b0001; ctrl[31:0] = mk(1, 3, 1, 0, 5, 1);
    lctrl[5*32] = 1'b0; apply("R7 link slot disabled");
    lctrl[5*32] = 1'b1; lctrl[5*32+20 +: 4] = 4'd4; apply("R7 link type not 3");
    lctrl[5*32+20 +: 4] = 4'd3; cur = 2'd2; apply("R7 link above level1");
    cur = 2'd0; lval[5*CW +: CW] = 32'h1234_5678; apply("R7 link ctx mismatch");
    lval[5*CW +: CW] = ctx; apply("R7 link ctx equal");
    // R8
    base(); hit = 4'b0010; long_d = 1; apply("R8 long format");
    long_d = 0; apply("R8 short format");
    // R9
    base(); hit = 4'b1010; apply("R9 lowest of two");
    hit = 4'b1000; apply("R9 top only");
    ctrl[1*32] = 1'b0; hit = 4'b1010; apply("R9 lower fails upper wins");
    // random sweep, biased toward linked matches
    for (int k = 0; k < 4000; k++) begin
      hit = N'($urandom);
      for (int i = 0; i < N; i++)
        ctrl[i*32 +: 32] = mk(($urandom % 8) != 0, $urandom, $urandom, $urandom,
                              3 + ($urandom % 4), $urandom);
      is_wp = 1'($urandom); unpriv = 1'($urandom); secure = 1'($urandom);
      cur = 2'($urandom); mon_en = ($urandom % 8) != 0; exc_en = ($urandom % 8) != 0;
      long_d = 1'($urandom); ctx = ($urandom % 2) ? 32'hCAFE_0001 : $urandom;
      for (int j = 0; j < L; j++) begin
        lctrl[j*32 +: 32] = (32'(($urandom % 4) != 0)) |
                            ((($urandom % 2) ? 32'd3 : 32'($urandom % 16)) << 20);
        lval[j*CW +: CW] = ($urandom % 2) ? ctx : $urandom;
      end
      apply("R9 random sweep");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule